// File: doc/BRIEF.md
# Serial Register Port for a Real-Time Clock

This block is the serial-bus face of a real-time clock. An SPI master talking in mode 3 (clock idles high, data sampled on the rising edge, launched on the falling edge) sends one command byte per chip-select window. The command picks read or write, the clock group or the scratch memory, and an index. The transfer then moves one byte, or a stream of bytes in one of two burst modes. One burst covers the eight clock-group registers and the other covers the 31 scratch bytes.

The timekeeping counters and the alarm logic live outside. A read of the clock group first freezes the counters' current value, taken from `liveTime`, into an internal holding copy, and every byte of that read is served from the copy. Writes to the clock group collect in a shadow buffer and reach the counters only as a one-cycle load pulse with a byte mask, issued when chip select rises. Accesses to register indices above the clock group go to the alarm logic as an access strobe. All pins are brought into the system clock domain by a synchronizer, so the serial clock must be several times slower than `clk`.

Top module: `rtc_spi_port`

## Requirements
- R1: The command byte arrives MSB first. Bit 7 = 1 means read and 0 means write. Bit 6 = 1 selects scratch memory and 0 selects the clock group. Bits 5:1 are the index. A single write to a scratch index is returned unchanged by a later single read of that index.
- R2: A command whose bit 0 is 0 changes nothing. No scratch byte changes, no load pulse is issued and the control byte keeps its value.
- R3: `miso` is launched on falling edges of `sclk`. The first data bit is driven on the falling edge that follows the eighth rising edge of the command. `misoOe` is low before that edge.
- R4: `misoOe` is low while `csN` is high and throughout any write transaction.
- R5: Command BFh reads eight bytes in this order: seconds, minutes, hours, date, month, weekday, year, control. The seven time bytes are captured from `liveTime` (byte i at bits 8i+7:8i, seconds at i = 0) when the command byte completes, so later changes of `liveTime` do not appear in that transfer.
- R6: Command 3Fh writes the same eight bytes. On the `csN` rise a single `timeLoadMask` pulse of 7Fh is issued, with the new bytes on `timeLoadData`, only if all eight bytes arrived. A shorter burst issues no pulse.
- R7: A single write to a time index (0 to 6) is held until `csN` rises. It then issues one pulse with only that index's mask bit set. A data byte cut short by `csN` issues no pulse.
- R8: Command 7Fh writes scratch bytes from index 0 upward, and each byte fully received is stored. Command FFh reads indices 0 to 30, after which `misoOe` falls.
- R9: Control index 7 holds a write-protect flag in bit 7 and a free flag in bit 0. Bits 6:1 read as 0. While the flag is 1, time loads and scratch writes are blocked, but the control byte can still be written.
- R10: Once a single-byte access is complete, further `sclk` cycles in the same window shift nothing in or out and have no effect.
- R11: A `csN` rise at any point returns the port to waiting for a command byte.
- R12: A completed data byte at register index 8 to 30 produces a one-cycle `accStb` carrying the index, the direction and, for writes, the byte. Such indices read as 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, idles high |
| csN | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| misoOe | output | 1 | Output enable for the `miso` pad driver |
| liveTime | input | 56 | Running counter bytes, seconds in the low byte |
| timeLoadMask | output | 7 | One-cycle load pulse, one bit per time byte |
| timeLoadData | output | 56 | New time bytes, valid during the pulse |
| accStb | output | 1 | Access strobe for indices 8 to 30 |
| accIdx | output | 5 | Index of the access |
| accWr | output | 1 | 1 for a write access |
| accData | output | 8 | Written byte (00h for reads) |

## Verification
The embedded properties watch the control state every cycle. They check that a chip-select rise always lands in the command-wait state with the output disabled, and that the output enable is never raised outside a read. They check that extra clocks after a finished access leave the counters untouched, and that the clock-group burst index stays within eight bytes. They also check that each load pulse follows a chip-select rise while write protect was clear. The byte order of the bursts, the snapshot freeze, the partial-byte aborts, the suppression of writes whose command has bit 0 clear, and the data returned by scratch and control reads can only be shown by the bench's transactions. The bench scoreboard compares every byte shifted out against its own model.

// File: rtl/rtc_spi_pkg.sv
package rtc_spi_pkg;
  localparam int TIME_BYTES = 7;
  localparam int CLK_GROUP  = 8;
  localparam int IDX_W      = 5;
  localparam logic [IDX_W-1:0] BURST_IDX = '1;
  localparam logic [IDX_W-1:0] CTRL_IDX  = 5'd7;

  typedef enum logic [1:0] {ST_CMD, ST_DATA, ST_DONE} portState_t;

  typedef struct packed {
    logic             cmdDone;
    logic             byteDone;
    logic             loadTx;
    logic             shiftTx;
    logic             csEnd;
    logic             commitOk;
    logic             isRead;
    logic             isRam;
    logic             wrEn;
    logic [IDX_W-1:0] regIdx;
    logic [7:0]       rxByte;
  } spiStb_t;
endpackage

// File: rtl/rtc_spi_ctrl.sv
module rtc_spi_ctrl
  import rtc_spi_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RAM_DEPTH   = 31
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclk,
  input  logic    csN,
  input  logic    mosi,
  output spiStb_t stb,
  output logic    misoOe
);
  localparam logic [IDX_W-1:0] RAM_LAST = IDX_W'(RAM_DEPTH - 1);
  localparam logic [IDX_W-1:0] CLK_LAST = IDX_W'(CLK_GROUP - 1);
  localparam logic [IDX_W-1:0] CLK_FULL = IDX_W'(CLK_GROUP);

  logic [SYNC_STAGES:0] sclkSr, csSr, mosiSr;
  logic sclkRise, sclkFall, csRise, csActive, mosiS;
  portState_t state;
  logic [2:0] bitCnt;
  logic [IDX_W-1:0] byteIdx;
  logic [7:0] rxSr, cmdQ;
  logic txActive, isBurst, lastBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSr <= '1;
      csSr   <= '1;
      mosiSr <= '0;
    end else begin
      sclkSr <= {sclkSr[SYNC_STAGES-1:0], sclk};
      csSr   <= {csSr[SYNC_STAGES-1:0], csN};
      mosiSr <= {mosiSr[SYNC_STAGES-1:0], mosi};
    end
  end

  assign sclkRise = sclkSr[SYNC_STAGES-1] & ~sclkSr[SYNC_STAGES];
  assign sclkFall = ~sclkSr[SYNC_STAGES-1] & sclkSr[SYNC_STAGES];
  assign csRise   = csSr[SYNC_STAGES-1] & ~csSr[SYNC_STAGES];
  assign csActive = ~csSr[SYNC_STAGES-1];
  assign mosiS    = mosiSr[SYNC_STAGES-1];
  assign isBurst  = (cmdQ[5:1] == BURST_IDX);
  assign lastBit  = sclkRise && csActive && (bitCnt == 3'd7) && (state != ST_DONE);

  always_comb begin
    stb.rxByte   = {rxSr[6:0], mosiS};
    stb.cmdDone  = lastBit && (state == ST_CMD);
    stb.byteDone = lastBit && (state == ST_DATA);
    stb.loadTx   = sclkFall && csActive && (state == ST_DATA) && (bitCnt == 3'd0) && cmdQ[7];
    stb.shiftTx  = sclkFall && csActive && (state == ST_DATA) && (bitCnt != 3'd0) && cmdQ[7];
    stb.csEnd    = csRise;
    stb.isRead   = cmdQ[7];
    stb.isRam    = cmdQ[6];
    stb.wrEn     = cmdQ[0];
    stb.regIdx   = isBurst ? byteIdx : cmdQ[5:1];
    stb.commitOk = !cmdQ[7] && !cmdQ[6] && cmdQ[0] && (state != ST_CMD) && (bitCnt == 3'd0) &&
                   (isBurst ? (byteIdx == CLK_FULL) : (byteIdx != '0));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_CMD;
      bitCnt   <= '0;
      byteIdx  <= '0;
      rxSr     <= '0;
      cmdQ     <= '0;
      txActive <= 1'b0;
    end else if (csRise) begin
      state    <= ST_CMD;
      bitCnt   <= '0;
      byteIdx  <= '0;
      txActive <= 1'b0;
    end else if (csActive) begin
      if (sclkRise && state != ST_DONE) begin
        rxSr   <= stb.rxByte;
        bitCnt <= bitCnt + 3'd1;
        if (bitCnt == 3'd7) begin
          if (state == ST_CMD) begin
            cmdQ    <= stb.rxByte;
            state   <= ST_DATA;
            byteIdx <= '0;
          end else begin
            byteIdx <= byteIdx + 1'b1;
            if (!isBurst || (!cmdQ[6] && byteIdx == CLK_LAST) || (cmdQ[6] && byteIdx == RAM_LAST))
              state <= ST_DONE;
          end
        end
      end
      if (stb.loadTx) txActive <= 1'b1;
    end
  end

  assign misoOe = txActive && (state == ST_DATA);

  // R11: chip-select rise always restarts at the command byte
  p_cs_restart_r11: assert property (@(posedge clk) disable iff (!rstN)
    stb.csEnd |=> (state == ST_CMD) && (bitCnt == 3'd0) && !misoOe);
  // R4: the output is enabled only for a read command
  p_oe_read_only_r4: assert property (@(posedge clk) disable iff (!rstN)
    misoOe |-> cmdQ[7]);
  // R4: no output while chip select stays high
  p_oe_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!csActive && !stb.csEnd) |-> !misoOe);
  // R10: clocks after a finished access change nothing
  p_done_ignores_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE && sclkRise && !csRise) |=> (state == ST_DONE) && $stable(bitCnt) && $stable(byteIdx));
  // R5: the clock-group burst never passes its eighth byte
  p_clk_burst_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA && !cmdQ[6]) |-> (byteIdx < CLK_FULL));
endmodule

// File: rtl/rtc_spi_dpath.sv
module rtc_spi_dpath
  import rtc_spi_pkg::*;
#(
  parameter int RAM_DEPTH = 31
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  spiStb_t                 stb,
  input  logic [TIME_BYTES*8-1:0] liveTime,
  output logic                    miso,
  output logic [TIME_BYTES-1:0]   timeLoadMask,
  output logic [TIME_BYTES*8-1:0] timeLoadData,
  output logic                    accStb,
  output logic [IDX_W-1:0]        accIdx,
  output logic                    accWr,
  output logic [7:0]              accData
);
  logic [CLK_GROUP-1:0][7:0]  shadow;
  logic [CLK_GROUP-1:0]       shMask;
  logic [TIME_BYTES-1:0][7:0] snap;
  logic [7:0] ram [RAM_DEPTH];
  logic [7:0] txSr, rdByte;
  logic ctrlWp, ctrlId;
  logic idxInClk, idxInRam, wrAllowed;

  assign idxInClk  = int'(stb.regIdx) < CLK_GROUP;
  assign idxInRam  = int'(stb.regIdx) < RAM_DEPTH;
  assign wrAllowed = stb.wrEn && !stb.isRead;

  always_comb begin
    rdByte = 8'h00;
    if (stb.isRam) begin
      if (idxInRam) rdByte = ram[stb.regIdx];
    end else if (stb.regIdx == CTRL_IDX) begin
      rdByte = {ctrlWp, 6'b0, ctrlId};
    end else if (int'(stb.regIdx) < TIME_BYTES) begin
      rdByte = snap[stb.regIdx[2:0]];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadow       <= '0;
      shMask       <= '0;
      snap         <= '0;
      txSr         <= '0;
      ctrlWp       <= 1'b0;
      ctrlId       <= 1'b0;
      timeLoadMask <= '0;
      accStb       <= 1'b0;
      accIdx       <= '0;
      accWr        <= 1'b0;
      accData      <= '0;
      for (int i = 0; i < RAM_DEPTH; i++) ram[i] <= '0;
    end else begin
      timeLoadMask <= '0;
      accStb       <= 1'b0;
      if (stb.cmdDone && stb.rxByte[7] && !stb.rxByte[6]) snap <= liveTime;
      if (stb.loadTx) txSr <= rdByte;
      else if (stb.shiftTx) txSr <= {txSr[6:0], 1'b0};
      if (stb.byteDone) begin
        if (!stb.isRam && idxInClk && wrAllowed) begin
          shadow[stb.regIdx[2:0]] <= stb.rxByte;
          shMask[stb.regIdx[2:0]] <= 1'b1;
        end
        if (stb.isRam && idxInRam && wrAllowed && !ctrlWp) ram[stb.regIdx] <= stb.rxByte;
        if (!stb.isRam && !idxInClk && (stb.isRead || (stb.wrEn && !ctrlWp))) begin
          accStb  <= 1'b1;
          accIdx  <= stb.regIdx;
          accWr   <= !stb.isRead;
          accData <= stb.isRead ? 8'h00 : stb.rxByte;
        end
      end
      if (stb.csEnd) begin
        shMask <= '0;
        if (stb.commitOk) begin
          timeLoadMask <= ctrlWp ? '0 : shMask[TIME_BYTES-1:0];
          if (shMask[CTRL_IDX[2:0]]) begin
            ctrlWp <= shadow[CTRL_IDX[2:0]][7];
            ctrlId <= shadow[CTRL_IDX[2:0]][0];
          end
        end
      end
    end
  end

  assign timeLoadData = shadow[TIME_BYTES-1:0];
  assign miso         = txSr[7];

  // R6/R7: a load pulse only ever follows a chip-select rise
  p_load_after_cs_r6: assert property (@(posedge clk) disable iff (!rstN)
    (timeLoadMask != '0) |-> $past(stb.csEnd));
  // R9: no load while write protect was set
  p_load_unprotected_r9: assert property (@(posedge clk) disable iff (!rstN)
    (timeLoadMask != '0) |-> !$past(ctrlWp));
  // R12: the access strobe lasts one cycle
  p_acc_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    accStb |=> !accStb);
endmodule

// File: rtl/rtc_spi_port.sv
module rtc_spi_port
  import rtc_spi_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RAM_DEPTH   = 31
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sclk,
  input  logic                    csN,
  input  logic                    mosi,
  output logic                    miso,
  output logic                    misoOe,
  input  logic [TIME_BYTES*8-1:0] liveTime,
  output logic [TIME_BYTES-1:0]   timeLoadMask,
  output logic [TIME_BYTES*8-1:0] timeLoadData,
  output logic                    accStb,
  output logic [IDX_W-1:0]        accIdx,
  output logic                    accWr,
  output logic [7:0]              accData
);
  spiStb_t stb;

  rtc_spi_ctrl #(.SYNC_STAGES(SYNC_STAGES), .RAM_DEPTH(RAM_DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi),
    .stb(stb), .misoOe(misoOe)
  );

  rtc_spi_dpath #(.RAM_DEPTH(RAM_DEPTH)) uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .liveTime(liveTime), .miso(miso),
    .timeLoadMask(timeLoadMask), .timeLoadData(timeLoadData),
    .accStb(accStb), .accIdx(accIdx), .accWr(accWr), .accData(accData)
  );
endmodule

// File: tb/tb_rtc_spi_port.sv
module tb_rtc_spi_port;
  logic clk = 1'b0, rstN = 1'b0, sclk = 1'b1, csN = 1'b1, mosi = 1'b0;
  logic miso, misoOe, accStb, accWr;
  logic [55:0] liveTime, timeLoadData;
  logic [6:0] timeLoadMask;
  logic [4:0] accIdx;
  logic [7:0] accData;

  rtc_spi_port dut (.*);

  always #5 clk = ~clk;

  int nChecks = 0, nFails = 0;
  logic [7:0] txBuf [0:39];
  logic [7:0] expQ[$];
  string reqQ[$];
  logic [7:0] ramModel [0:30];
  int monCnt = 0, monBitTotal = 0, loadCnt = 0, accCnt = 0;
  logic [7:0] monSh = 0;
  logic [6:0] lastMask = 0;
  logic [55:0] lastData = 0;
  logic [4:0] lastAccIdx = 0;
  logic lastAccWr = 0, oeSeen = 0;
  logic [7:0] lastAccData = 0;
  localparam logic [55:0] L1 = 56'h99_07_12_31_13_59_59;
  localparam logic [55:0] L2 = 56'h00_01_01_01_00_00_05;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pushExp(input logic [7:0] v, input string req);
    expQ.push_back(v);
    reqQ.push_back(req);
  endtask

  // scoreboard monitor: rebuilds each byte seen on miso and pops the expectation
  always @(posedge sclk or posedge csN) begin
    if (csN) monCnt = 0;
    else if (misoOe) begin
      monSh = {monSh[6:0], miso};
      monCnt++;
      monBitTotal++;
      if (monCnt == 8) begin
        monCnt = 0;
        if (expQ.size() == 0) chk(0, "R1", "unexpected read byte", monSh, 0);
        else begin
          automatic logic [7:0] e = expQ.pop_front();
          automatic string r = reqQ.pop_front();
          chk(monSh == e, r, "read byte", monSh, e);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (misoOe) oeSeen = 1;
    if (timeLoadMask != 0) begin
      loadCnt++; lastMask = timeLoadMask; lastData = timeLoadData;
    end
    if (accStb) begin
      accCnt++; lastAccIdx = accIdx; lastAccWr = accWr; lastAccData = accData;
    end
  end

  task automatic halfWait();
    repeat (8) @(negedge clk);
  endtask

  task automatic xfer(input int nBytes, input int extraBits, input bit alt);
    automatic bit rd = txBuf[0][7] && nBytes > 1;
    oeSeen = 0;
    csN = 0;
    halfWait();
    for (int i = 0; i < nBytes*8 + extraBits; i++) begin
      sclk = 0; mosi = txBuf[i/8][7-(i%8)];
      halfWait();
      if (rd && i == 8) chk(misoOe == 1, "R3", "oe after first data fall", misoOe, 1);
      sclk = 1;
      halfWait();
      if (rd && i == 7) chk(misoOe == 0, "R3", "oe before first data fall", misoOe, 0);
      if (alt && i == 7) liveTime = L2;
    end
    csN = 1; mosi = 0;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R11", "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    automatic int lc, bt;
    liveTime = L1;
    for (int i = 0; i < 31; i++) ramModel[i] = 8'h00;
    repeat (4) @(negedge clk);
    rstN = 1;
    repeat (4) @(negedge clk);
    chk(misoOe == 0, "R4", "oe after reset", misoOe, 0);
    chk(timeLoadMask == 0, "R6", "no load after reset", timeLoadMask, 0);

    // R5: burst read, counters change after the command but the snapshot holds
    txBuf[0] = 8'hBF;
    for (int i = 0; i < 7; i++) pushExp(L1[8*i +: 8], "R5");
    pushExp(8'h00, "R5");
    xfer(9, 0, 1);
    txBuf[0] = 8'h81; pushExp(L2[7:0], "R5");
    xfer(2, 0, 0);

    // R6: full clock burst write
    lc = loadCnt;
    txBuf[0] = 8'h3F; txBuf[1] = 8'h31; txBuf[2] = 8'h11; txBuf[3] = 8'hB0; txBuf[4] = 8'h04;
    txBuf[5] = 8'h07; txBuf[6] = 8'h05; txBuf[7] = 8'h02; txBuf[8] = 8'h00;
    xfer(9, 0, 0);
    chk(loadCnt == lc + 1, "R6", "burst load count", loadCnt - lc, 1);
    chk(lastMask == 7'h7F, "R6", "burst load mask", lastMask, 7'h7F);
    chk(lastData == 56'h02_05_07_04_B0_11_31, "R6", "burst load data", lastData, 56'h02_05_07_04_B0_11_31);
    chk(oeSeen == 0, "R4", "oe during write", oeSeen, 0);
    // R6: short burst is discarded
    lc = loadCnt;
    xfer(6, 0, 0);
    chk(loadCnt == lc, "R6", "short burst load", loadCnt - lc, 0);

    // R7: single minutes write, then a partial one
    lc = loadCnt;
    txBuf[0] = 8'h03; txBuf[1] = 8'h45;
    xfer(2, 0, 0);
    chk(loadCnt == lc + 1 && lastMask == 7'h02, "R7", "single load mask", lastMask, 7'h02);
    chk(lastData[15:8] == 8'h45, "R7", "single load byte", lastData[15:8], 8'h45);
    lc = loadCnt;
    xfer(1, 4, 0);
    chk(loadCnt == lc, "R7", "partial byte load", loadCnt - lc, 0);
    // R2: clear LSB blocks clock writes
    txBuf[0] = 8'h02;
    xfer(2, 0, 0);
    chk(loadCnt == lc, "R2", "LSB clear load", loadCnt - lc, 0);

    // R1/R2: scratch single write and blocked write
    txBuf[0] = 8'h45; txBuf[1] = 8'h5A; xfer(2, 0, 0); ramModel[2] = 8'h5A;
    txBuf[0] = 8'h44; txBuf[1] = 8'hAA; xfer(2, 0, 0);
    txBuf[0] = 8'hC5; pushExp(8'h5A, "R2"); xfer(2, 0, 0);

    // R8: RAM burst with a partial fourth byte, then full burst read
    txBuf[0] = 8'h7F; txBuf[1] = 8'hA1; txBuf[2] = 8'hB2; txBuf[3] = 8'hC3; txBuf[4] = 8'hFF;
    xfer(4, 4, 0);
    ramModel[0] = 8'hA1; ramModel[1] = 8'hB2; ramModel[2] = 8'hC3;
    txBuf[0] = 8'hFF;
    for (int i = 0; i < 31; i++) pushExp(ramModel[i], "R8");
    bt = monBitTotal;
    xfer(33, 0, 0);
    chk(monBitTotal - bt == 248, "R8", "bits driven in RAM burst read", monBitTotal - bt, 248);

    // R9: write protect
    txBuf[0] = 8'h0F; txBuf[1] = 8'hFF; xfer(2, 0, 0);
    txBuf[0] = 8'h8F; pushExp(8'h81, "R9"); xfer(2, 0, 0);
    lc = loadCnt;
    txBuf[0] = 8'h01; txBuf[1] = 8'h11; xfer(2, 0, 0);
    chk(loadCnt == lc, "R9", "load while protected", loadCnt - lc, 0);
    txBuf[0] = 8'h41; txBuf[1] = 8'h77; xfer(2, 0, 0);
    txBuf[0] = 8'hC1; pushExp(8'hA1, "R9"); xfer(2, 0, 0);
    txBuf[0] = 8'h0F; txBuf[1] = 8'h00; xfer(2, 0, 0);
    txBuf[0] = 8'h8F; pushExp(8'h00, "R9"); xfer(2, 0, 0);

    // R10: extra clocks after single accesses
    lc = loadCnt;
    txBuf[0] = 8'h03; txBuf[1] = 8'h22; txBuf[2] = 8'hFF; xfer(3, 0, 0);
    chk(loadCnt == lc + 1 && lastMask == 7'h02 && lastData[15:8] == 8'h22, "R10", "write with trailing clocks",
        lastData[15:8], 8'h22);
    txBuf[0] = 8'hC1; pushExp(8'hA1, "R10");
    bt = monBitTotal;
    xfer(3, 0, 0);
    chk(monBitTotal - bt == 8, "R10", "bits driven by single read", monBitTotal - bt, 8);

    // R11: chip select rises inside a command
    txBuf[0] = 8'hC0; xfer(0, 4, 0);
    txBuf[0] = 8'hC1; pushExp(8'hA1, "R11"); xfer(2, 0, 0);

    // R12: access strobe for alarm-side indices
    lc = accCnt;
    txBuf[0] = 8'h15; txBuf[1] = 8'h3C; xfer(2, 0, 0);
    chk(accCnt == lc + 1 && lastAccIdx == 5'd10 && lastAccWr == 1, "R12", "write access idx", lastAccIdx, 10);
    chk(lastAccData == 8'h3C, "R12", "write access data", lastAccData, 8'h3C);
    txBuf[0] = 8'h95; pushExp(8'h00, "R12"); xfer(2, 0, 0);
    chk(accCnt == lc + 2 && lastAccWr == 0, "R12", "read access", lastAccWr, 0);

    chk(expQ.size() == 0, "R1", "scoreboard drained", expQ.size(), 0);
    chk(misoOe == 0, "R4", "oe idle at end", misoOe, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule